// File: doc/BRIEF.md
# Programmable Logic Macrocell

This block is one output cell of a programmable logic array. A sum-of-products term enters a polarity XOR. The XOR result is then either stored or passed straight through. The storage can work as an edge-triggered D register, a level-sensitive flow-through latch or a toggle flip-flop.

The storage takes its clock from one of several global clock lines, from one of the local clock lines or from a product-term clock. Its enable, reset and preset are each chosen from a set of candidate sources in the same way. Every control signal has its own polarity bit.

The cell has two outputs, one toward the local array and one toward the routing fabric. Each output selects on its own between the stored value and the XOR result. This lets one output carry a registered function while the other carries the plain combinational term. All behaviour is set by a static configuration word, which is meant to change only while the control inputs are quiet.

Top module: `pal_macrocell`

## Requirements
- R1: The combinational result equals `sum_in` XOR the invert bit `cfg_word[2]`.
- R2: With mode field `cfg_word[1:0]` = 0 (bypass), both outputs carry the R1 result whatever their select bits hold.
- R3: With mode 1 (D register), a rising edge of the effective clock while the enable is active loads the R1 result into the register.
- R4: With mode 3 (toggle), an enabled rising edge of the effective clock inverts the register when the R1 result is 1 and leaves it unchanged when the result is 0.
- R5: With mode 2 (latch), the latch follows the R1 result while the effective clock is high and the enable is active. It holds its value otherwise.
- R6: The clock source field `cfg_word[4:3]` selects the effective clock: 0 = none (constant low), 1 = global line `g_clk[idx]`, 2 = local line `l_clk[idx]`, 3 = `pt_clk`. The index field is `cfg_word[18:17]`. A local index at or beyond the number of local lines gives a constant low. Bit `cfg_word[5]` inverts the chosen clock, so the register then acts on the falling edge.
- R7: The enable source field `cfg_word[7:6]` works as follows: 0 = always enabled, 1 = `g_ce`, 2 = `l_ce`, 3 = `pt_ce`. Bit `cfg_word[8]` inverts the chosen enable. While the enable is inactive, clock edges leave the stored value unchanged.
- R8: The reset source field `cfg_word[10:9]` works as follows: 1 = `g_rst`, 3 = `pt_rst`, 0 or 2 = never. Bit `cfg_word[11]` inverts the chosen reset. Reset clears both storage elements at once, without a clock, and wins over preset.
- R9: The preset source field `cfg_word[13:12]` works as follows: 1 = `g_set`, 3 = `pt_set`, 0 or 2 = never. Bit `cfg_word[14]` inverts the chosen preset. Preset sets the storage to 1 at once whenever reset is inactive. When reset is released while preset is still active, the latch returns to 1 immediately. The register stays 0 until its next preset or clock event.
- R10: Outside bypass mode, `fb_out` is selected by `cfg_word[15]` and `rt_out` by `cfg_word[16]`, each on its own: 0 = stored value, 1 = R1 result. The stored value is the latch in mode 2 and the register in modes 1 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_word | input | 19 | Static configuration word (fields in R1 to R10) |
| sum_in | input | 1 | Sum-of-products term from the logic array |
| g_clk | input | 4 | Global clock lines |
| l_clk | input | 2 | Local clock lines |
| pt_clk | input | 1 | Product-term clock |
| g_ce | input | 1 | Global clock enable |
| l_ce | input | 1 | Local clock enable |
| pt_ce | input | 1 | Product-term clock enable |
| g_rst | input | 1 | Global reset |
| pt_rst | input | 1 | Product-term reset |
| g_set | input | 1 | Global preset |
| pt_set | input | 1 | Product-term preset |
| fb_out | output | 1 | Output toward the local array |
| rt_out | output | 1 | Output toward the routing fabric |

## Verification
Reset and preset can be active at the same moment, and either one can coincide with a clock edge that would otherwise load the register. The bench drives reset and preset pulses that overlap each other on purpose. It also raises preset while clocks keep toggling, and releases reset while preset is held. Random toggling of the control inputs then produces many more overlaps. An event-ordered reference model in the bench judges each step, with reset winning and the register ignoring a reset release. Checker properties confirm that both storage elements read 0 at every reset release, and that the latch reads 1 at every preset release made while reset is inactive.

// File: rtl/pal_mc_pkg.sv
`timescale 1ns/1ps
package pal_mc_pkg;

  typedef enum logic [1:0] {
    ST_COMB  = 2'd0,
    ST_DREG  = 2'd1,
    ST_LATCH = 2'd2,
    ST_TFF   = 2'd3
  } store_mode_e;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_GLOBAL = 2'd1,
    SRC_LOCAL  = 2'd2,
    SRC_PTERM  = 2'd3
  } src_code_e;

  // configuration word layout (fixed part; clock index sits on top)
  localparam int unsigned MODE_LSB    = 0;
  localparam int unsigned INV_BIT     = 2;
  localparam int unsigned CLK_SRC_LSB = 3;
  localparam int unsigned CLK_POL_BIT = 5;
  localparam int unsigned CE_SRC_LSB  = 6;
  localparam int unsigned CE_POL_BIT  = 8;
  localparam int unsigned RST_SRC_LSB = 9;
  localparam int unsigned RST_POL_BIT = 11;
  localparam int unsigned SET_SRC_LSB = 12;
  localparam int unsigned SET_POL_BIT = 14;
  localparam int unsigned FB_SEL_BIT  = 15;
  localparam int unsigned RT_SEL_BIT  = 16;
  localparam int unsigned CLK_IDX_LSB = 17;

  function automatic logic polarity_stage(input logic sum, input logic inv);
    return sum ^ inv;
  endfunction

  function automatic logic apply_pol(input logic sig, input logic inv);
    return sig ^ inv;
  endfunction

  // next value of the edge-triggered cell on an enabled edge
  function automatic logic edge_next(input store_mode_e mode, input logic q,
                                     input logic x);
    case (mode)
      ST_DREG: return x;
      ST_TFF:  return q ^ x;
      default: return q;
    endcase
  endfunction

  function automatic logic stored_view(input store_mode_e mode, input logic ff,
                                       input logic lat);
    return (mode == ST_LATCH) ? lat : ff;
  endfunction

endpackage

// File: rtl/pal_mc_ctlsel.sv
`timescale 1ns/1ps
// One-bit control source picker: global / local / product-term with polarity.
module pal_mc_ctlsel
  import pal_mc_pkg::*;
#(
  parameter logic IDLE_LEVEL = 1'b0,
  parameter bit   LOCAL_OK   = 1'b1
) (
  input  logic [1:0] code,
  input  logic       inv,
  input  logic       g_src,
  input  logic       l_src,
  input  logic       pt_src,
  output logic       sel_out
);

  always_comb begin
    case (src_code_e'(code))
      SRC_GLOBAL: sel_out = apply_pol(g_src, inv);
      SRC_LOCAL:  sel_out = LOCAL_OK ? apply_pol(l_src, inv) : IDLE_LEVEL;
      SRC_PTERM:  sel_out = apply_pol(pt_src, inv);
      default:    sel_out = IDLE_LEVEL;
    endcase
  end

endmodule

// File: rtl/pal_mc_clksel.sv
`timescale 1ns/1ps
// Effective clock picker with index range check and polarity.
module pal_mc_clksel
  import pal_mc_pkg::*;
#(
  parameter int unsigned N_GCLK = 4,
  parameter int unsigned N_LCLK = 2,
  parameter int unsigned IDX_W  = 2
) (
  input  logic [1:0]        code,
  input  logic [IDX_W-1:0]  idx,
  input  logic              inv,
  input  logic [N_GCLK-1:0] g_clk,
  input  logic [N_LCLK-1:0] l_clk,
  input  logic              pt_clk,
  output logic              eclk
);

  localparam int unsigned SLOTS = 1 << IDX_W;

  logic [SLOTS-1:0] g_pad, g_vld, l_pad, l_vld;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (i < N_GCLK) begin : g_have
      assign g_pad[i] = g_clk[i];
      assign g_vld[i] = 1'b1;
    end else begin : g_none
      assign g_pad[i] = 1'b0;
      assign g_vld[i] = 1'b0;
    end
    if (i < N_LCLK) begin : l_have
      assign l_pad[i] = l_clk[i];
      assign l_vld[i] = 1'b1;
    end else begin : l_none
      assign l_pad[i] = 1'b0;
      assign l_vld[i] = 1'b0;
    end
  end

  always_comb begin
    case (src_code_e'(code))
      SRC_GLOBAL: eclk = g_vld[idx] ? apply_pol(g_pad[idx], inv) : 1'b0;
      SRC_LOCAL:  eclk = l_vld[idx] ? apply_pol(l_pad[idx], inv) : 1'b0;
      SRC_PTERM:  eclk = apply_pol(pt_clk, inv);
      default:    eclk = 1'b0;
    endcase
  end

endmodule

// File: rtl/pal_mc_store.sv
`timescale 1ns/1ps
// Storage: edge cell (D or toggle) and flow-through latch, async clear/set.
module pal_mc_store
  import pal_mc_pkg::*;
(
  input  logic        eclk,
  input  logic        rst_a,
  input  logic        set_a,
  input  logic        ce,
  input  store_mode_e mode,
  input  logic        x,
  output logic        ff_q,
  output logic        lat_q
);

  logic lat_open;

  always_ff @(posedge eclk or posedge rst_a or posedge set_a) begin
    if (rst_a)      ff_q <= 1'b0;
    else if (set_a) ff_q <= 1'b1;
    else if (ce)    ff_q <= edge_next(mode, ff_q, x);
  end

  assign lat_open = (mode == ST_LATCH) && eclk && ce;

  always_latch begin
    if (rst_a)         lat_q <= 1'b0;
    else if (set_a)    lat_q <= 1'b1;
    else if (lat_open) lat_q <= x;
  end

endmodule

// File: rtl/pal_mc_outsel.sv
`timescale 1ns/1ps
// One output port: stored value or combinational term; bypass forces the term.
module pal_mc_outsel
  import pal_mc_pkg::*;
(
  input  store_mode_e mode,
  input  logic        pick_comb,
  input  logic        comb_val,
  input  logic        stored_val,
  output logic        out_val
);

  assign out_val = (mode == ST_COMB || pick_comb) ? comb_val : stored_val;

endmodule

// File: rtl/pal_macrocell.sv
`timescale 1ns/1ps
module pal_macrocell
  import pal_mc_pkg::*;
#(
  parameter int unsigned N_GCLK  = 4,
  parameter int unsigned N_LCLK  = 2,
  localparam int unsigned MAX_CLK = (N_GCLK > N_LCLK) ? N_GCLK : N_LCLK,
  localparam int unsigned IDX_W   = (MAX_CLK > 1) ? $clog2(MAX_CLK) : 1,
  localparam int unsigned CFG_W   = CLK_IDX_LSB + IDX_W
) (
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic              sum_in,
  input  logic [N_GCLK-1:0] g_clk,
  input  logic [N_LCLK-1:0] l_clk,
  input  logic              pt_clk,
  input  logic              g_ce,
  input  logic              l_ce,
  input  logic              pt_ce,
  input  logic              g_rst,
  input  logic              pt_rst,
  input  logic              g_set,
  input  logic              pt_set,
  output logic              fb_out,
  output logic              rt_out
);

  localparam int unsigned N_OUT = 2;

  store_mode_e mode;
  logic        xor_out;
  logic        eclk, ce_eff, rst_eff, set_eff;
  logic        ff_q, lat_q, stored_q;
  logic        fb_sel, rt_sel;
  logic [N_OUT-1:0] pick_comb, outs;

  assign mode    = store_mode_e'(cfg_word[MODE_LSB +: 2]);
  assign xor_out = polarity_stage(sum_in, cfg_word[INV_BIT]);
  assign fb_sel  = cfg_word[FB_SEL_BIT];
  assign rt_sel  = cfg_word[RT_SEL_BIT];

  pal_mc_clksel #(.N_GCLK(N_GCLK), .N_LCLK(N_LCLK), .IDX_W(IDX_W)) u_clk (
    .code  (cfg_word[CLK_SRC_LSB +: 2]),
    .idx   (cfg_word[CLK_IDX_LSB +: IDX_W]),
    .inv   (cfg_word[CLK_POL_BIT]),
    .g_clk (g_clk),
    .l_clk (l_clk),
    .pt_clk(pt_clk),
    .eclk  (eclk)
  );

  pal_mc_ctlsel #(.IDLE_LEVEL(1'b1), .LOCAL_OK(1'b1)) u_ce (
    .code(cfg_word[CE_SRC_LSB +: 2]), .inv(cfg_word[CE_POL_BIT]),
    .g_src(g_ce), .l_src(l_ce), .pt_src(pt_ce), .sel_out(ce_eff)
  );

  pal_mc_ctlsel #(.IDLE_LEVEL(1'b0), .LOCAL_OK(1'b0)) u_rst (
    .code(cfg_word[RST_SRC_LSB +: 2]), .inv(cfg_word[RST_POL_BIT]),
    .g_src(g_rst), .l_src(1'b0), .pt_src(pt_rst), .sel_out(rst_eff)
  );

  pal_mc_ctlsel #(.IDLE_LEVEL(1'b0), .LOCAL_OK(1'b0)) u_set (
    .code(cfg_word[SET_SRC_LSB +: 2]), .inv(cfg_word[SET_POL_BIT]),
    .g_src(g_set), .l_src(1'b0), .pt_src(pt_set), .sel_out(set_eff)
  );

  pal_mc_store u_store (
    .eclk (eclk),
    .rst_a(rst_eff),
    .set_a(set_eff),
    .ce   (ce_eff),
    .mode (mode),
    .x    (xor_out),
    .ff_q (ff_q),
    .lat_q(lat_q)
  );

  assign stored_q  = stored_view(mode, ff_q, lat_q);
  assign pick_comb = {rt_sel, fb_sel};

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    pal_mc_outsel u_os (
      .mode      (mode),
      .pick_comb (pick_comb[k]),
      .comb_val  (xor_out),
      .stored_val(stored_q),
      .out_val   (outs[k])
    );
  end

  assign fb_out = outs[0];
  assign rt_out = outs[1];

endmodule

// File: rtl/pal_mc_checker.sv
`timescale 1ns/1ps
module pal_mc_checker (
  input logic       eclk,
  input logic       rst_eff,
  input logic       set_eff,
  input logic       ce_eff,
  input logic [1:0] mode,
  input logic       xor_out,
  input logic       ff_q,
  input logic       lat_q,
  input logic       fb_sel,
  input logic       rt_sel,
  input logic       fb_out,
  input logic       rt_out
);

  // marks an asynchronous clear/set since the last effective clock edge
  logic async_hit;
  always_ff @(posedge eclk or posedge rst_eff or posedge set_eff) begin
    if (rst_eff || set_eff) async_hit <= 1'b1;
    else                    async_hit <= 1'b0;
  end

  p_comb_bypass_r2: assert property (@(posedge eclk)
    (mode == 2'd0) |-> (fb_out == xor_out && rt_out == xor_out));

  p_dreg_load_r3: assert property (@(posedge eclk) disable iff (rst_eff || set_eff)
    (mode == 2'd1 && ce_eff) |=> (async_hit || ff_q == $past(xor_out)));

  p_toggle_r4: assert property (@(posedge eclk) disable iff (rst_eff || set_eff)
    (mode == 2'd3 && ce_eff) |=> (async_hit || ff_q == ($past(ff_q) ^ $past(xor_out))));

  p_latch_flow_r5: assert property (@(negedge eclk) disable iff (rst_eff || set_eff)
    (mode == 2'd2 && ce_eff) |-> (lat_q == xor_out));

  p_enable_hold_r7: assert property (@(posedge eclk) disable iff (rst_eff || set_eff)
    (!ce_eff) |=> (async_hit || ff_q == $past(ff_q)));

  p_reset_wins_r8: assert property (@(negedge rst_eff)
    (ff_q == 1'b0 && lat_q == 1'b0));

  p_preset_r9: assert property (@(negedge set_eff)
    (!rst_eff) |-> (lat_q == 1'b1));

  p_fb_pick_r10: assert property (@(posedge eclk)
    (mode != 2'd0) |-> (fb_out == (fb_sel ? xor_out : ((mode == 2'd2) ? lat_q : ff_q))));

  p_rt_pick_r10: assert property (@(posedge eclk)
    (mode != 2'd0) |-> (rt_out == (rt_sel ? xor_out : ((mode == 2'd2) ? lat_q : ff_q))));

endmodule

bind pal_macrocell pal_mc_checker u_chk (
  .eclk   (eclk),
  .rst_eff(rst_eff),
  .set_eff(set_eff),
  .ce_eff (ce_eff),
  .mode   (mode),
  .xor_out(xor_out),
  .ff_q   (ff_q),
  .lat_q  (lat_q),
  .fb_sel (fb_sel),
  .rt_sel (rt_sel),
  .fb_out (fb_out),
  .rt_out (rt_out)
);

// File: tb/pal_macrocell_test.sv
`timescale 1ns/1ps
module pal_macrocell_test;

  localparam int NG = 4;
  localparam int NL = 2;
  localparam int CW = 19;

  logic tb_clk = 1'b0;
  always #2.5 tb_clk = ~tb_clk;

  logic [CW-1:0] cfg_word = '0;
  logic          sum_in = 1'b0;
  logic [NG-1:0] g_clk = '0;
  logic [NL-1:0] l_clk = '0;
  logic pt_clk = 1'b0, g_ce = 1'b0, l_ce = 1'b0, pt_ce = 1'b0;
  logic g_rst = 1'b0, pt_rst = 1'b0, g_set = 1'b0, pt_set = 1'b0;
  logic fb_out, rt_out;

  pal_macrocell uut (
    .cfg_word(cfg_word), .sum_in(sum_in), .g_clk(g_clk), .l_clk(l_clk),
    .pt_clk(pt_clk), .g_ce(g_ce), .l_ce(l_ce), .pt_ce(pt_ce),
    .g_rst(g_rst), .pt_rst(pt_rst), .g_set(g_set), .pt_set(pt_set),
    .fb_out(fb_out), .rt_out(rt_out)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit m_ff = 1'b0, m_lat = 1'b0, p_e = 1'b0, p_r = 1'b0, p_s = 1'b0;

  function automatic bit pick(input bit [1:0] code, input bit inv, input bit g,
                              input bit l, input bit pt, input bit idle, input bit lok);
    case (code)
      2'd1:    return g ^ inv;
      2'd2:    return lok ? (l ^ inv) : idle;
      2'd3:    return pt ^ inv;
      default: return idle;
    endcase
  endfunction

  function automatic logic [CW-1:0] mk_cfg(
      input bit [1:0] md, input bit inv, input bit [1:0] csrc, input bit [1:0] cidx,
      input bit cpol, input bit [1:0] cesrc, input bit cepol, input bit [1:0] rsrc,
      input bit rpol, input bit [1:0] ssrc, input bit spol, input bit fbs, input bit rts);
    return {cidx, rts, fbs, spol, ssrc, rpol, rsrc, cepol, cesrc, cpol, csrc, inv, md};
  endfunction

  function automatic string mode_tag(input bit [1:0] md);
    case (md)
      2'd0:    return "R2";
      2'd1:    return "R3";
      2'd2:    return "R5";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // inputs change at negedge; the model and the compare run at the next posedge
  task automatic settle(input string tag);
    bit e, r, s, c, x, lok, gsig, lsig, st, exp_fb, exp_rt;
    bit [1:0] md, idx;
    @(posedge tb_clk);
    md   = cfg_word[1:0];
    idx  = cfg_word[18:17];
    lok  = (int'(idx) < NL);
    gsig = g_clk[idx];
    lsig = lok ? l_clk[idx[0]] : 1'b0;
    e = pick(cfg_word[4:3], cfg_word[5], gsig, lsig, pt_clk, 1'b0, lok);
    c = pick(cfg_word[7:6], cfg_word[8], g_ce, l_ce, pt_ce, 1'b1, 1'b1);
    r = pick(cfg_word[10:9], cfg_word[11], g_rst, 1'b0, pt_rst, 1'b0, 1'b0);
    s = pick(cfg_word[13:12], cfg_word[14], g_set, 1'b0, pt_set, 1'b0, 1'b0);
    x = sum_in ^ cfg_word[2];
    if ((r && !p_r) || (s && !p_s) || (e && !p_e)) begin
      if (r)                    m_ff = 1'b0;
      else if (s)               m_ff = 1'b1;
      else if (c && md == 2'd1) m_ff = x;
      else if (c && md == 2'd3) m_ff = m_ff ^ x;
    end
    if (r)                          m_lat = 1'b0;
    else if (s)                     m_lat = 1'b1;
    else if (md == 2'd2 && e && c)  m_lat = x;
    p_e = e; p_r = r; p_s = s;
    st     = (md == 2'd2) ? m_lat : m_ff;
    exp_fb = (md == 2'd0 || cfg_word[15]) ? x : st;
    exp_rt = (md == 2'd0 || cfg_word[16]) ? x : st;
    check(tag, "fb_out", fb_out, exp_fb);
    check(tag, "rt_out", rt_out, exp_rt);
  endtask

  // configuration changes one field group per step so no two controls move together
  task automatic set_cfg(input logic [CW-1:0] nc, input string tag);
    logic [CW-1:0] masks [6];
    masks[0] = 19'h00E00;
    masks[1] = 19'h07000;
    masks[2] = 19'h001C0;
    masks[3] = 19'h18003;
    masks[4] = 19'h00004;
    masks[5] = 19'h60038;
    for (int g = 0; g < 6; g++) begin
      @(negedge tb_clk);
      cfg_word = (cfg_word & ~masks[g]) | (nc & masks[g]);
      settle(tag);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge tb_clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    // reset state and priority (R8)
    set_cfg(mk_cfg(2'd1, 0, 2'd1, 2'd0, 0, 2'd0, 0, 2'd1, 0, 2'd3, 0, 0, 1), "R8");
    @(negedge tb_clk); g_rst = 1'b1;  settle("R8");
    @(negedge tb_clk); pt_set = 1'b1; settle("R8");
    @(negedge tb_clk); g_clk[0] = 1'b1; settle("R8");
    @(negedge tb_clk); g_clk[0] = 1'b0; pt_set = 1'b0; settle("R8");
    @(negedge tb_clk); g_rst = 1'b0;  settle("R8");
    // D capture, independent outputs (R3, R10)
    @(negedge tb_clk); sum_in = 1'b1;   settle("R3");
    @(negedge tb_clk); g_clk[0] = 1'b1; settle("R3");
    @(negedge tb_clk); g_clk[0] = 1'b0; settle("R3");
    @(negedge tb_clk); sum_in = 1'b0;   settle("R10");
    @(negedge tb_clk); g_clk[0] = 1'b1; settle("R3");
    @(negedge tb_clk); g_clk[0] = 1'b0; settle("R3");
    // preset, and reset released under preset (R9)
    @(negedge tb_clk); pt_set = 1'b1; settle("R9");
    @(negedge tb_clk); g_rst = 1'b1;  settle("R9");
    @(negedge tb_clk); g_rst = 1'b0;  settle("R9");
    @(negedge tb_clk); pt_set = 1'b0; settle("R9");
    // polarity XOR (R1)
    set_cfg(mk_cfg(2'd1, 1, 2'd1, 2'd0, 0, 2'd0, 0, 2'd1, 0, 2'd3, 0, 0, 1), "R1");
    @(negedge tb_clk); sum_in = 1'b1; settle("R1");
    @(negedge tb_clk); sum_in = 1'b0; settle("R1");
    // toggle (R4)
    set_cfg(mk_cfg(2'd3, 0, 2'd1, 2'd2, 0, 2'd0, 0, 2'd0, 0, 2'd0, 0, 0, 1), "R4");
    @(negedge tb_clk); sum_in = 1'b1; settle("R4");
    for (int i = 0; i < 4; i++) begin
      @(negedge tb_clk); g_clk[2] = ~g_clk[2]; settle("R4");
    end
    @(negedge tb_clk); sum_in = 1'b0; settle("R4");
    for (int i = 0; i < 2; i++) begin
      @(negedge tb_clk); g_clk[2] = ~g_clk[2]; settle("R4");
    end
    // enable hold (R7)
    set_cfg(mk_cfg(2'd1, 0, 2'd1, 2'd2, 0, 2'd1, 0, 2'd0, 0, 2'd0, 0, 0, 1), "R7");
    @(negedge tb_clk); sum_in = 1'b1;   settle("R7");
    @(negedge tb_clk); g_clk[2] = 1'b1; settle("R7");
    @(negedge tb_clk); g_clk[2] = 1'b0; g_ce = 1'b1; settle("R7");
    @(negedge tb_clk); g_clk[2] = 1'b1; settle("R7");
    @(negedge tb_clk); g_clk[2] = 1'b0; settle("R7");
    // latch transparency (R5)
    set_cfg(mk_cfg(2'd2, 0, 2'd3, 2'd0, 0, 2'd0, 0, 2'd0, 0, 2'd0, 0, 0, 1), "R5");
    @(negedge tb_clk); pt_clk = 1'b1; settle("R5");
    @(negedge tb_clk); sum_in = 1'b0; settle("R5");
    @(negedge tb_clk); sum_in = 1'b1; settle("R5");
    @(negedge tb_clk); pt_clk = 1'b0; settle("R5");
    @(negedge tb_clk); sum_in = 1'b0; settle("R5");
    // clock selection: local out of range, in range, inverted (R6)
    set_cfg(mk_cfg(2'd1, 0, 2'd2, 2'd3, 0, 2'd0, 0, 2'd0, 0, 2'd0, 0, 0, 1), "R6");
    @(negedge tb_clk); sum_in = 1'b1; settle("R6");
    for (int i = 0; i < 4; i++) begin
      @(negedge tb_clk); l_clk = l_clk ^ 2'b11; settle("R6");
    end
    set_cfg(mk_cfg(2'd1, 0, 2'd2, 2'd1, 1, 2'd0, 0, 2'd0, 0, 2'd0, 0, 0, 1), "R6");
    @(negedge tb_clk); sum_in = 1'b0;   settle("R6");
    @(negedge tb_clk); l_clk[1] = 1'b1; settle("R6");
    @(negedge tb_clk); l_clk[1] = 1'b0; settle("R6");
    // bypass ignores the output selects (R2)
    set_cfg(mk_cfg(2'd0, 0, 2'd2, 2'd1, 0, 2'd0, 0, 2'd0, 0, 2'd0, 0, 0, 0), "R2");
    @(negedge tb_clk); sum_in = 1'b1; settle("R2");
    @(negedge tb_clk); sum_in = 1'b0; settle("R2");
    // random stimulus
    for (int n = 0; n < 3000; n++) begin
      int unsigned r;
      r = $urandom % 20;
      if (r == 13) begin
        set_cfg(CW'($urandom), mode_tag(cfg_word[1:0]));
      end else begin
        @(negedge tb_clk);
        if (r < 6) begin
          int unsigned k;
          k = $urandom % 6;
          if (k < 4)       g_clk[k] = ~g_clk[k];
          else if (k == 4) l_clk[$urandom % 2] = ~l_clk[$urandom % 2];
          else             pt_clk = ~pt_clk;
        end else if (r < 9) begin
          sum_in = ~sum_in;
        end else if (r < 11) begin
          case ($urandom % 3)
            0:       g_ce = ~g_ce;
            1:       l_ce = ~l_ce;
            default: pt_ce = ~pt_ce;
          endcase
        end else if (r == 11) begin
          if ($urandom % 2 == 0) g_rst = ~g_rst; else pt_rst = ~pt_rst;
        end else if (r == 12) begin
          if ($urandom % 2 == 0) g_set = ~g_set; else pt_set = ~pt_set;
        end else begin
          sum_in = 1'($urandom);
        end
        settle(mode_tag(cfg_word[1:0]));
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule